// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block moves a system-on-chip into a low-power sleep state and back out of it. It is clocked by the system clock. An internal prescaler makes a slow tick of about 30.5 µs (a 32.768 kHz rate), and every wait in the sequence is counted in these ticks. When software requests sleep, the block first pulls the active-low system reset low. A short tick window later it drops the regulator enable.

While the block is asleep, it watches a bank of GPIO wake lines, each gated by its own mask bit. A wake line must be held long enough to pass qualification. A short pulse sends the block back to sleep. Once a wake is qualified, the block raises the regulator enable and then waits a fixed supply settling window of about 10 ms. After that it waits for the active-low supply-fault input to read healthy, and only then releases reset. An active battery fault (input low) blocks any wake-up. All asynchronous inputs pass through a synchronizer before the sequencer uses them.

Top module: `slp_pwr_seq`

## Requirements
- R1: After `rst_ni` is released, the block is in the running state: `sys_rst_no` is 1 and `pwr_en_o` is 1.
- R2: A high `sleep_req_i` in the running state drives `sys_rst_no` low within SYNC_STAGES+2 clock cycles, while `pwr_en_o` is still 1.
- R3: `pwr_en_o` falls between PD_TICKS and PD_TICKS+1 tick periods after `sys_rst_no` falls, and `pwr_en_o` is never 0 while `sys_rst_no` is 1.
- R4: A wake line must stay high for QUAL_TICKS tick strobes in a row to be accepted. If it drops before that, the block returns to sleep and `pwr_en_o` stays 0.
- R5: While `batt_fault_ni` is 0, no wake line can start or finish qualification, and `pwr_en_o` stays 0.
- R6: After a qualified wake, `pwr_en_o` rises PU_TICKS tick strobes after qualification ends. Measured from the rise of the GPIO, this is between QUAL_TICKS and QUAL_TICKS+PU_TICKS+1 tick periods, plus the synchronizer delay.
- R7: After `pwr_en_o` rises, `sys_rst_no` stays low for VCC_TICKS tick periods. After that it rises only once `vdd_fault_ni` has been 1 for the synchronizer delay.
- R8: `gpio_i[k]` counts as a wake source only when `wake_mask_i[k]` is 1. Any one of the N_GPIO lines can wake the block, and lines whose mask bit is 0 are ignored.
- R9: `sleep_req_i` has no effect while the block is asleep: `sys_rst_no` and `pwr_en_o` both stay 0.
- R10: Exactly one sequencer state is active in every cycle (one-hot state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep request, level-sampled in the running state |
| gpio_i | input | N_GPIO | Wake lines, active high |
| wake_mask_i | input | N_GPIO | Per-line wake enable |
| batt_fault_ni | input | 1 | Battery fault, active low; blocks wake |
| vdd_fault_ni | input | 1 | Supply fault, active low; holds reset |
| sys_rst_no | output | 1 | System reset, active low |
| pwr_en_o | output | 1 | Regulator enable |

## Verification
The embedded assertions check four things on every cycle. The state must stay one-hot. The regulator enable must never be off while reset is released. A sleeping sequencer may only stay asleep or start qualification, and without an unmasked, fault-free wake it must stay asleep. Reset may only rise after a sampled healthy supply, and the regulator may only turn on from the power-up state. The tick-window durations, the rejection of short wake pulses, and the effect of the mask on each line can only be shown by the bench's scenarios. For each scenario, the bench measures the delay between edges and compares it with the allowed window.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;
  typedef enum logic [7:0] {
    ST_RUN       = 8'b0000_0001,
    ST_RST_ON    = 8'b0000_0010,
    ST_PWR_DOWN  = 8'b0000_0100,
    ST_SLEEP     = 8'b0000_1000,
    ST_WAKE_QUAL = 8'b0001_0000,
    ST_PWR_UP    = 8'b0010_0000,
    ST_VCC_WAIT  = 8'b0100_0000,
    ST_RELEASE   = 8'b1000_0000
  } seq_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slp_tick_gen.sv
module slp_tick_gen #(
  parameter int unsigned DIV = 6104
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (DIV <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // a strobe is a single cycle when dividing
    assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/slp_tick_timer.sv
module slp_tick_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // expires on the strobe that empties the count
  assign expire_o = tick_i && (cnt_q <= CW'(1));
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
  import slp_seq_pkg::*;
#(
  parameter int unsigned CW        = 9,
  parameter int unsigned PD_TICKS  = 2,
  parameter int unsigned QUAL_TICKS = 3,
  parameter int unsigned PU_TICKS  = 1,
  parameter int unsigned VCC_TICKS = 328
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          expire_i,
  input  logic          sleep_req_i,
  input  logic          wake_ok_i,
  input  logic          vdd_ok_i,
  output seq_state_e    state_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (sleep_req_i) state_d = ST_RST_ON;
      ST_RST_ON:    if (tick_i)      state_d = ST_PWR_DOWN;
      ST_PWR_DOWN:  if (expire_i)    state_d = ST_SLEEP;
      ST_SLEEP:     if (wake_ok_i)   state_d = ST_WAKE_QUAL;
      ST_WAKE_QUAL: if (!wake_ok_i)  state_d = ST_SLEEP;
                    else if (expire_i) state_d = ST_PWR_UP;
      ST_PWR_UP:    if (expire_i)    state_d = ST_VCC_WAIT;
      ST_VCC_WAIT:  if (expire_i)    state_d = ST_RELEASE;
      ST_RELEASE:   if (vdd_ok_i)    state_d = ST_RUN;
      default:                       state_d = ST_RUN;
    endcase
  end

  // timer is loaded on every entry into a timed state
  always_comb begin
    load_o     = (state_d != state_q);
    load_val_o = '0;
    unique case (state_d)
      ST_PWR_DOWN:  load_val_o = CW'(PD_TICKS);
      ST_WAKE_QUAL: load_val_o = CW'(QUAL_TICKS);
      ST_PWR_UP:    load_val_o = CW'(PU_TICKS);
      ST_VCC_WAIT:  load_val_o = CW'(VCC_TICKS);
      default:      load_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_state_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));

  assert_sleep_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP) |=> (state_q == ST_SLEEP || state_q == ST_WAKE_QUAL));

  assert_no_wake_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !wake_ok_i) |=> (state_q == ST_SLEEP));

  assert_vcc_wait_from_pwr_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VCC_WAIT && $past(state_q) != ST_VCC_WAIT) |-> ($past(state_q) == ST_PWR_UP));
endmodule

// File: rtl/slp_pwr_seq.sv
module slp_pwr_seq
  import slp_seq_pkg::*;
#(
  parameter int unsigned N_GPIO      = 16,
  parameter int unsigned TICK_DIV    = 6104,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PD_TICKS    = 2,
  parameter int unsigned QUAL_TICKS  = 3,
  parameter int unsigned PU_TICKS    = 1,
  parameter int unsigned VCC_TICKS   = 328
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic [N_GPIO-1:0] wake_mask_i,
  input  logic              batt_fault_ni,
  input  logic              vdd_fault_ni,
  output logic              sys_rst_no,
  output logic              pwr_en_o
);
  localparam int unsigned MAXT = (VCC_TICKS > QUAL_TICKS) ? VCC_TICKS : QUAL_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam int unsigned SW   = N_GPIO + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {N_GPIO{1'b0}}};

  logic [SW-1:0]     sync_q;
  logic [N_GPIO-1:0] gpio_s;
  logic              sleep_req_s, batt_ok_s, vdd_ok_s;
  logic              tick, expire, load, wake_ok;
  logic [CW-1:0]     load_val;
  seq_state_e        state;

  slp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sleep_req_i, batt_fault_ni, vdd_fault_ni, gpio_i}),
    .q_o   (sync_q)
  );

  assign {sleep_req_s, batt_ok_s, vdd_ok_s, gpio_s} = sync_q;
  assign wake_ok = batt_ok_s && |(gpio_s & wake_mask_i);

  slp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  slp_tick_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (tick),
    .expire_o  (expire)
  );

  slp_seq_fsm #(
    .CW(CW), .PD_TICKS(PD_TICKS), .QUAL_TICKS(QUAL_TICKS),
    .PU_TICKS(PU_TICKS), .VCC_TICKS(VCC_TICKS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .expire_i   (expire),
    .sleep_req_i(sleep_req_s),
    .wake_ok_i  (wake_ok),
    .vdd_ok_i   (vdd_ok_s),
    .state_o    (state),
    .load_o     (load),
    .load_val_o (load_val)
  );

  assign sys_rst_no = (state == ST_RUN);
  assign pwr_en_o   = (state == ST_RUN) || (state == ST_RST_ON) || (state == ST_PWR_DOWN) ||
                      (state == ST_VCC_WAIT) || (state == ST_RELEASE);

  assert_rst_covers_pwr_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !sys_rst_no);

  assert_release_needs_supply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> ($past(vdd_ok_s) && pwr_en_o));
endmodule

// File: tb/tb_slp_pwr_seq.sv
`timescale 1ns/1ps
module tb_slp_pwr_seq;
  localparam int DIV = 4, SYNC = 2, PD = 2, QUAL = 3, PU = 1, VCC = 8;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, batt_n = 1, vdd_n = 1;
  logic [15:0] gpio = '0, mask = '0;
  logic sys_rst_n, pwr_en;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  slp_pwr_seq #(.N_GPIO(16), .TICK_DIV(DIV), .SYNC_STAGES(SYNC), .PD_TICKS(PD),
    .QUAL_TICKS(QUAL), .PU_TICKS(PU), .VCC_TICKS(VCC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .gpio_i(gpio),
    .wake_mask_i(mask), .batt_fault_ni(batt_n), .vdd_fault_ni(vdd_n),
    .sys_rst_no(sys_rst_n), .pwr_en_o(pwr_en));

  // {gpio, mask, hold cycles, batt ok, expect wake}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {16'h0001, 16'h0001, 8'd40, 1'b1, 1'b1},
    {16'h8000, 16'h8000, 8'd40, 1'b1, 1'b1},
    {16'h0010, 16'hffef, 8'd40, 1'b1, 1'b0},
    {16'h0100, 16'h0100, 8'd5,  1'b1, 1'b0},
    {16'h0004, 16'hffff, 8'd40, 1'b0, 1'b0},
    {16'hffff, 16'h0000, 8'd40, 1'b1, 1'b0},
    {16'h0a00, 16'h0200, 8'd40, 1'b1, 1'b1},
    {16'h0001, 16'h0001, 8'd6,  1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_lvl(input bit use_rst, input logic v, input int max, output int n);
    n = 0;
    while (((use_rst ? sys_rst_n : pwr_en) !== v) && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic go_sleep();
    int n;
    sleep_req = 1;
    wait_lvl(0, 1'b0, 100, n);
    sleep_req = 0;
  endtask

  task automatic restore();
    int n;
    batt_n = 1; vdd_n = 1; mask = 16'h0001; gpio = 16'h0001;
    cycles(40);
    gpio = '0;
    wait_lvl(1, 1'b1, 200, n);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, a, b;
    cycles(3);
    rst_n = 1;
    cycles(2);
    // R1: running after reset
    check("R1 rst", sys_rst_n, 1);
    check("R1 pwr", pwr_en, 1);

    // R2, R3: sleep entry windows
    sleep_req = 1;
    wait_lvl(1, 1'b0, 50, a);
    check_rng("R2 rst fall delay", a, 1, SYNC + 2);
    check("R2 pwr still on", pwr_en, 1);
    wait_lvl(0, 1'b0, 50, b);
    sleep_req = 0;
    check_rng("R3 pwr fall after rst", b, PD * DIV, (PD + 1) * DIV + 1);
    check("R3 rst low when pwr off", sys_rst_n, 0);

    // R9: sleep request while asleep
    sleep_req = 1;
    cycles(30);
    check("R9 pwr", pwr_en, 0);
    check("R9 rst", sys_rst_n, 0);
    sleep_req = 0;

    // R6, R7: wake windows with supply fault held
    vdd_n = 0; mask = 16'h0040; gpio = 16'h0040;
    wait_lvl(0, 1'b1, 100, a);
    check_rng("R6 pwr rise delay", a, QUAL * DIV, (QUAL + PU + 1) * DIV + SYNC + 2);
    gpio = '0;
    cycles(VCC * DIV + 20);
    check("R7 rst held by supply fault", sys_rst_n, 0);
    vdd_n = 1;
    wait_lvl(1, 1'b1, 50, a);
    check_rng("R7 rst rise after supply ok", a, 1, SYNC + 2);

    // R7: settle window with supply healthy
    go_sleep();
    mask = 16'h0001; gpio = 16'h0001;
    wait_lvl(0, 1'b1, 100, a);
    gpio = '0;
    wait_lvl(1, 1'b1, 200, b);
    check_rng("R7 settle window", b, VCC * DIV, VCC * DIV + 3);

    // R4, R5, R8: wake vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] g, m;
      logic [7:0] h;
      logic bo, ex;
      {g, m, h, bo, ex} = VEC[v];
      go_sleep();
      batt_n = bo; mask = m; gpio = g;
      cycles(h);
      gpio = '0;
      cycles(20);
      check($sformatf("R4/R5/R8 vec%0d pwr", v), pwr_en, ex);
      restore();
      check($sformatf("R8 vec%0d restored", v), sys_rst_n, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule